// File: doc/BRIEF.md
# Text-Mode Character Row Pixel Generator

This block turns one scan line of one character cell into a short burst of colour indices. Each row job is given a 16-bit character word, with the code in the low byte and the attribute in the high byte. It also takes the font byte for the current line, the line number inside the cell, and a handful of display settings: cell width, cell height, cursor band limits, the line-graphics option and an upstream flag that marks this cell as the cursor cell. After a start strobe the block emits 8 or 9 pixels, one per clock, as 4-bit indices into a palette that lies outside this block.

The block also returns the font row address for the job, which is the code times 32 plus the line number. A text renderer fetches the character word and its font byte and pulses start once per cell. It can pulse start again during the last pixel of a cell, so that cells follow one another with no gap.

Top module: `glyph_row_gen`

## Requirements
- R1: After reset, pix_valid_o, pix_done_o and pix_idx_o are all 0.
- R2: The first pixel appears in the cycle after the clock edge that samples an accepted start. pix_valid_o then stays high for exactly 8 cycles when narrow_i=1, or 9 cycles when narrow_i=0. pix_done_o is high only in the last of those cycles.
- R3: The foreground index is char_word_i[11:8] and the background index is char_word_i[15:12]. The character code is char_word_i[7:0].
- R4: Pixels 1 to 8 take font_byte_i bit 7 down to bit 0, in that order. A 1 bit gives foreground and a 0 bit gives background.
- R5: In 9-wide cells the ninth pixel repeats the eighth when lg_en_i=1 and the code is in 0xB0..0xDF inclusive. Otherwise it is background.
- R6: No cursor is drawn when cursor_hit_i=0 or when cur_start_i[5]=1.
- R7: With the cursor enabled, the cursor rows run from cur_start_i[4:0] to min(cur_end_i, cell_h_m1_i), where the cell height is cell_h_m1_i+1. On such a row every pixel of the cell is foreground, including the ninth.
- R8: No cursor is drawn when min(cur_end_i, cell_h_m1_i) < cur_start_i[4:0], or when cur_start_i[4:0] > cell_h_m1_i.
- R9: font_addr_o becomes code*32 + row_i on the edge that accepts a start. It then holds until the next accepted start.
- R10: A start is accepted when the block is idle or when it is showing the last pixel of a row, which makes back-to-back rows possible. A start at any other time has no effect on the pixels or on font_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Row job strobe; inputs sampled with it |
| char_word_i | input | 16 | Attribute (high byte) and code (low byte) |
| font_byte_i | input | 8 | Font bits for this line, MSB leftmost |
| row_i | input | 5 | Line number inside the cell |
| narrow_i | input | 1 | 1 = 8-pixel cell, 0 = 9-pixel cell |
| cell_h_m1_i | input | 5 | Cell height minus one |
| cur_start_i | input | 6 | Cursor first line [4:0]; bit 5 turns the cursor off |
| cur_end_i | input | 5 | Cursor last line before clipping |
| lg_en_i | input | 1 | Line-graphics ninth-column repeat enable |
| cursor_hit_i | input | 1 | This cell holds the cursor |
| pix_valid_o | output | 1 | Pixel index valid |
| pix_idx_o | output | 4 | Colour index of the current pixel |
| pix_done_o | output | 1 | Last pixel of the row |
| font_addr_o | output | 13 | Font row address of the accepted job |

## Verification
The assertions assume that every job input is stable and meaningful in the cycle in which start_i is high. They also assume that the start strobe is a single-cycle pulse sampled on a rising edge. The bench changes its inputs only on falling edges, always together with start, and keeps the line number and the cursor fields within 5 bits. One deliberate exception checks that a start raised in the middle of a row, carrying different inputs, leaves the pixel stream and the font address untouched.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  // Code range that gets the ninth-column repeat
  localparam logic [7:0] LG_FIRST = 8'hB0;
  localparam logic [7:0] LG_LAST  = 8'hDF;

  typedef enum logic { CELL_W9 = 1'b0, CELL_W8 = 1'b1 } cell_mode_e;

  function automatic logic in_lg_range(input logic [7:0] code);
    return (code >= LG_FIRST) && (code <= LG_LAST);
  endfunction
endpackage

// File: rtl/glyph_cursor_band.sv
module glyph_cursor_band #(
  parameter int ROW_W = 5
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] hm1_i,
  input  logic [ROW_W:0]   cstart_i,
  input  logic [ROW_W-1:0] cend_i,
  input  logic             hit_i,
  output logic             in_band_o
);
  logic [ROW_W-1:0] first_row;
  logic [ROW_W-1:0] last_row;
  logic             off;
  logic             band_ok;

  always_comb begin
    first_row = cstart_i[ROW_W-1:0];
    off       = cstart_i[ROW_W];
    last_row  = (cend_i < hm1_i) ? cend_i : hm1_i;
    band_ok   = (first_row <= hm1_i) && (last_row >= first_row);
    in_band_o = hit_i && !off && band_ok &&
                (row_i >= first_row) && (row_i <= last_row);
  end
endmodule

// File: rtl/glyph_pattern.sv
module glyph_pattern
  import glyph_pkg::*;
#(
  parameter int FONT_W = 8,
  parameter int CODE_W = 8
) (
  input  logic [FONT_W-1:0] font_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              lg_en_i,
  input  logic              cursor_row_i,
  output logic [FONT_W:0]   pat_o
);
  logic dup_ninth;

  // Font columns go to the upper pattern bits, MSB first
  for (genvar i = 0; i < FONT_W; i++) begin : g_col
    assign pat_o[i+1] = cursor_row_i | font_i[i];
  end

  always_comb begin
    dup_ninth = lg_en_i && in_lg_range(8'(code_i));
    pat_o[0]  = cursor_row_i | (dup_ninth & font_i[0]);
  end
endmodule

// File: rtl/glyph_serializer.sv
module glyph_serializer #(
  parameter int COLOR_W = 4,
  parameter int PIX_N   = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [PIX_N-1:0]   pat_i,
  input  logic               narrow_i,
  input  logic [COLOR_W-1:0] fg_i,
  input  logic [COLOR_W-1:0] bg_i,
  output logic               ready_o,
  output logic               pix_valid_o,
  output logic [COLOR_W-1:0] pix_idx_o,
  output logic               pix_done_o
);
  localparam int CNT_W = $clog2(PIX_N);
  localparam logic [CNT_W-1:0] REM_WIDE   = CNT_W'(PIX_N - 1);
  localparam logic [CNT_W-1:0] REM_NARROW = CNT_W'(PIX_N - 2);

  logic [PIX_N-1:0]   shift_q;
  logic [CNT_W-1:0]   rem_q;
  logic [COLOR_W-1:0] fg_q, bg_q;
  logic               nar_q;
  logic [CNT_W-1:0]   run_q;

  assign ready_o = !pix_valid_o || (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q     <= '0;
      rem_q       <= '0;
      fg_q        <= '0;
      bg_q        <= '0;
      nar_q       <= 1'b0;
      run_q       <= '0;
      pix_valid_o <= 1'b0;
      pix_idx_o   <= '0;
      pix_done_o  <= 1'b0;
    end else if (load_i) begin
      fg_q        <= fg_i;
      bg_q        <= bg_i;
      nar_q       <= narrow_i;
      pix_idx_o   <= pat_i[PIX_N-1] ? fg_i : bg_i;
      shift_q     <= pat_i << 1;
      rem_q       <= narrow_i ? REM_NARROW : REM_WIDE;
      run_q       <= '0;
      pix_valid_o <= 1'b1;
      pix_done_o  <= 1'b0;
    end else if (pix_valid_o) begin
      if (rem_q == '0) begin
        pix_valid_o <= 1'b0;
        pix_done_o  <= 1'b0;
      end else begin
        pix_idx_o  <= shift_q[PIX_N-1] ? fg_q : bg_q;
        shift_q    <= shift_q << 1;
        rem_q      <= rem_q - 1'b1;
        run_q      <= run_q + 1'b1;
        pix_done_o <= (rem_q == CNT_W'(1));
      end
    end
  end

  AST_DONE_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    pix_done_o |-> pix_valid_o); // R2
  AST_DONE_ENDS_ROW: assert property (@(posedge clk) disable iff (rst)
    (pix_done_o && !load_i) |=> !pix_valid_o); // R2
  AST_ROW_LENGTH: assert property (@(posedge clk) disable iff (rst)
    pix_done_o |-> (run_q == (nar_q ? REM_NARROW : REM_WIDE))); // R2
endmodule

// File: rtl/glyph_row_gen.sv
module glyph_row_gen
  import glyph_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int COLOR_W = 4,
  parameter int FONT_W  = 8,
  parameter int ROW_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [CODE_W+2*COLOR_W-1:0] char_word_i,
  input  logic [FONT_W-1:0]         font_byte_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic                      narrow_i,
  input  logic [ROW_W-1:0]          cell_h_m1_i,
  input  logic [ROW_W:0]            cur_start_i,
  input  logic [ROW_W-1:0]          cur_end_i,
  input  logic                      lg_en_i,
  input  logic                      cursor_hit_i,
  output logic                      pix_valid_o,
  output logic [COLOR_W-1:0]        pix_idx_o,
  output logic                      pix_done_o,
  output logic [CODE_W+ROW_W-1:0]   font_addr_o
);
  localparam int PIX_N = FONT_W + 1;

  logic [CODE_W-1:0]  code;
  logic [COLOR_W-1:0] fg, bg;
  logic               cursor_row;
  logic [PIX_N-1:0]   pat;
  logic               ready;
  logic               accept;

  assign code   = char_word_i[CODE_W-1:0];
  assign fg     = char_word_i[CODE_W +: COLOR_W];
  assign bg     = char_word_i[CODE_W+COLOR_W +: COLOR_W];
  assign accept = start_i && ready && !rst;

  glyph_cursor_band #(.ROW_W(ROW_W)) cursor_i (
    .row_i     (row_i),
    .hm1_i     (cell_h_m1_i),
    .cstart_i  (cur_start_i),
    .cend_i    (cur_end_i),
    .hit_i     (cursor_hit_i),
    .in_band_o (cursor_row)
  );

  glyph_pattern #(.FONT_W(FONT_W), .CODE_W(CODE_W)) pattern_i (
    .font_i       (font_byte_i),
    .code_i       (code),
    .lg_en_i      (lg_en_i),
    .cursor_row_i (cursor_row),
    .pat_o        (pat)
  );

  glyph_serializer #(.COLOR_W(COLOR_W), .PIX_N(PIX_N)) ser_i (
    .clk         (clk),
    .rst         (rst),
    .load_i      (accept),
    .pat_i       (pat),
    .narrow_i    (narrow_i),
    .fg_i        (fg),
    .bg_i        (bg),
    .ready_o     (ready),
    .pix_valid_o (pix_valid_o),
    .pix_idx_o   (pix_idx_o),
    .pix_done_o  (pix_done_o)
  );

  // Font row address: code times 2**ROW_W plus the line number
  always_ff @(posedge clk) begin
    if (rst) font_addr_o <= '0;
    else if (accept) font_addr_o <= {code, row_i};
  end

  AST_BAND_INSIDE_CELL: assert property (@(posedge clk) disable iff (rst)
    (accept && cursor_row) |-> (row_i >= cur_start_i[ROW_W-1:0] &&
                                row_i <= cell_h_m1_i && row_i <= cur_end_i)); // R7
  AST_CURSOR_FIRST_FG: assert property (@(posedge clk) disable iff (rst)
    (accept && cursor_row) |=> (pix_idx_o == $past(fg))); // R7
  AST_NO_HIT_FONT: assert property (@(posedge clk) disable iff (rst)
    (accept && (!cursor_hit_i || cur_start_i[ROW_W])) |=>
      (pix_idx_o == ($past(font_byte_i[FONT_W-1]) ? $past(fg) : $past(bg)))); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(accept) |-> $stable(font_addr_o)); // R9
endmodule

// File: tb/glyph_row_gen_tb_top.sv
module glyph_row_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] char_word_i = '0;
  logic [7:0]  font_byte_i = '0;
  logic [4:0]  row_i = '0;
  logic        narrow_i = 1'b0;
  logic [4:0]  cell_h_m1_i = 5'd15;
  logic [5:0]  cur_start_i = 6'h20;
  logic [4:0]  cur_end_i = '0;
  logic        lg_en_i = 1'b0;
  logic        cursor_hit_i = 1'b0;
  logic        pix_valid_o;
  logic [3:0]  pix_idx_o;
  logic        pix_done_o;
  logic [12:0] font_addr_o;

  int checks = 0;
  int fails  = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_row_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .char_word_i(char_word_i),
    .font_byte_i(font_byte_i), .row_i(row_i), .narrow_i(narrow_i),
    .cell_h_m1_i(cell_h_m1_i), .cur_start_i(cur_start_i), .cur_end_i(cur_end_i),
    .lg_en_i(lg_en_i), .cursor_hit_i(cursor_hit_i), .pix_valid_o(pix_valid_o),
    .pix_idx_o(pix_idx_o), .pix_done_o(pix_done_o), .font_addr_o(font_addr_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare each produced pixel with the scoreboard head
  always @(negedge clk) begin
    if (!rst && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected pixel", {pix_done_o, pix_idx_o}, 5'h1f ^ {pix_done_o, pix_idx_o});
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {pix_done_o, pix_idx_o}, e);
      end
    end else if (!rst && pix_done_o) begin
      check("R2 done without valid", 1, 0);
    end
  end

  // Driver: compute expectation, push it, pulse start; returns in last-pixel cycle
  task automatic run_row(input logic [7:0] code, input logic [7:0] attr,
                         input logic [7:0] font, input logic [4:0] row,
                         input logic narrow, input logic [4:0] hm1,
                         input logic [5:0] cs, input logic [4:0] ce,
                         input logic lg, input logic hit,
                         input string tag, input bit intrude);
    int w;
    logic [4:0] last;
    logic cur;
    logic [8:0] bits;
    w = narrow ? 8 : 9;
    last = (ce < hm1) ? ce : hm1;
    cur = hit && !cs[5] && (cs[4:0] <= hm1) && (last >= cs[4:0]) &&
          (row >= cs[4:0]) && (row <= last);
    for (int i = 0; i < 8; i++) bits[8-i] = cur | font[7-i];
    bits[0] = cur | (lg && code >= 8'hB0 && code <= 8'hDF && font[0]);
    for (int i = 0; i < w; i++) begin
      exp_q.push_back({(i == w-1), (bits[8-i] ? attr[3:0] : attr[7:4])});
      tag_q.push_back(tag);
    end
    char_word_i = {attr, code}; font_byte_i = font; row_i = row;
    narrow_i = narrow; cell_h_m1_i = hm1; cur_start_i = cs; cur_end_i = ce;
    lg_en_i = lg; cursor_hit_i = hit; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R9 font address", font_addr_o, {code, row});
    for (int k = 1; k < w; k++) begin
      @(negedge clk);
      if (intrude && k == 3) begin
        char_word_i = 16'h7733; font_byte_i = 8'h0F; row_i = 5'd9;
        start_i = 1'b1;
      end
      if (intrude && k == 4) begin
        start_i = 1'b0;
        check("R10 address held during row", font_addr_o, {code, row});
      end
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    @(negedge clk);
    check("R2 valid low after row", pix_valid_o, 0);
    check("R10 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", pix_valid_o, 0);
    check("R1 done after reset", pix_done_o, 0);
    check("R1 index after reset", pix_idx_o, 0);

    // R3 R4 basic colours and bit order, both widths (R2)
    run_row(8'h41, 8'h1E, 8'hA5, 5'd3, 1'b0, 5'd15, 6'h20, 5'd0, 1'b0, 1'b0, "R4 wide row", 0);
    idle_check();
    run_row(8'h41, 8'hC3, 8'h5A, 5'd7, 1'b1, 5'd15, 6'h20, 5'd0, 1'b0, 1'b0, "R2 narrow row", 0);
    idle_check();
    // R5 ninth column cases
    run_row(8'hC4, 8'h2A, 8'h81, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b1, 1'b0, "R5 repeat in range", 0);
    run_row(8'hC4, 8'h2A, 8'h81, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b0, 1'b0, "R5 repeat disabled", 0);
    run_row(8'hAF, 8'h2A, 8'h01, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b1, 1'b0, "R5 below range", 0);
    run_row(8'hE0, 8'h2A, 8'h01, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b1, 1'b0, "R5 above range", 0);
    run_row(8'hDF, 8'h5C, 8'h01, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b1, 1'b0, "R5 top edge", 0);
    run_row(8'hB0, 8'h5C, 8'h01, 5'd1, 1'b0, 5'd15, 6'h20, 5'd0, 1'b1, 1'b0, "R5 bottom edge", 0);
    idle_check();
    // R7 cursor band
    run_row(8'h20, 8'h07, 8'h00, 5'd3, 1'b0, 5'd15, 6'd2, 5'd5, 1'b0, 1'b1, "R7 cursor row wide", 0);
    run_row(8'h20, 8'h07, 8'h00, 5'd6, 1'b0, 5'd15, 6'd2, 5'd5, 1'b0, 1'b1, "R7 below band", 0);
    run_row(8'h20, 8'h34, 8'h10, 5'd2, 1'b1, 5'd15, 6'd2, 5'd5, 1'b0, 1'b1, "R7 cursor row narrow", 0);
    run_row(8'h20, 8'h34, 8'h10, 5'd13, 1'b0, 5'd13, 6'd10, 5'd20, 1'b0, 1'b1, "R7 clipped last row", 0);
    run_row(8'h20, 8'h34, 8'h10, 5'd14, 1'b0, 5'd13, 6'd10, 5'd20, 1'b0, 1'b1, "R7 past clip", 0);
    idle_check();
    // R6 cursor disabled
    run_row(8'h20, 8'h07, 8'h42, 5'd3, 1'b0, 5'd15, 6'h22, 5'd5, 1'b0, 1'b1, "R6 off bit", 0);
    run_row(8'h20, 8'h07, 8'h42, 5'd3, 1'b0, 5'd15, 6'd2, 5'd5, 1'b0, 1'b0, "R6 no hit", 0);
    // R8 empty bands
    run_row(8'h20, 8'h61, 8'h18, 5'd4, 1'b0, 5'd15, 6'd6, 5'd4, 1'b0, 1'b1, "R8 end before start", 0);
    run_row(8'h20, 8'h61, 8'h18, 5'd20, 1'b0, 5'd15, 6'd20, 5'd25, 1'b0, 1'b1, "R8 start past height", 0);
    idle_check();
    // R10 start in mid row is ignored
    run_row(8'h55, 8'h9E, 8'hC3, 5'd8, 1'b0, 5'd15, 6'h20, 5'd0, 1'b0, 1'b0, "R10 intruded row", 1);
    idle_check();
    check("R10 address after ignored start", font_addr_o, {8'h55, 5'd8});

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule